// File: doc/BRIEF.md
# Nibble BCD/Hex Arithmetic Unit

This block is the arithmetic core of a digit-serial calculator datapath. Each clock it takes one 4-bit digit from each of two operands, `opd_s` and `opd_r`, plus a carry or borrow bit from the previous digit. A 3-bit operation code selects what happens to them. The code comes straight from a three-bit slice of the microinstruction word, at bits 13 down to 11. The block returns a 4-bit digit and a carry or borrow bit.

The operations are:
- clear the result
- pass either operand
- exclusive-or the two operands
- add with carry, in plain binary or in packed decimal with correction
- subtract with borrow, in plain binary or in packed decimal with correction

Code zero gives an all-zero result. A microinstruction that leaves the field empty therefore leaves the unit idle.

The result path is purely combinational. A parameter chooses whether the carry output is also captured in a one-bit flag register, which the next digit's step can consume. The flag register is reset low. Operand multiplexers and digit registers sit outside this block.

Top module: `nib_alu`

## Requirements
- R1: Operation code 000 drives `res` to 0000 and `cy_out` to 0 for every operand and carry input.
- R2: Code 001 drives `res` equal to `opd_s`, and code 010 drives `res` equal to `opd_r`.
- R3: Code 011 drives `res` to the bitwise exclusive-or of `opd_s` and `opd_r`.
- R4: For codes 001, 010 and 011, `cy_out` is 0 whatever `cy_in` is.
- R5: Code 100 (binary add) gives `res` = low four bits of `opd_s + opd_r + cy_in`, and `cy_out` = bit 4 of that 5-bit sum.
- R6: Code 101 (decimal add) forms t = `opd_s + opd_r + cy_in`. If t > 9, `res` = (t + 6) mod 16 and `cy_out` = 1. Otherwise `res` = t and `cy_out` = 0. When both operands are 0..9, `res` stays within 0..9.
- R7: Code 110 (binary subtract) gives `res` = (`opd_s - opd_r - cy_in`) mod 16, and `cy_out` = 1 exactly when that difference is negative.
- R8: Code 111 (decimal subtract) forms d = `opd_s - opd_r - cy_in`. If d < 0, `res` = (d - 6) mod 16 and `cy_out` = 1. Otherwise `res` = d and `cy_out` = 0. When both operands are 0..9, `res` stays within 0..9.
- R9: With the registered variant (REG_CARRY = 1, the default), `cy_flag` holds 0 while `rst_n` is low. Afterwards, each rising clock edge loads it with the `cy_out` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the carry flag |
| fn_code | input | 3 | Operation code, microinstruction bits 13..11 |
| opd_s | input | 4 | First operand digit |
| opd_r | input | 4 | Second operand digit |
| cy_in | input | 1 | Carry (add) or borrow (subtract) input |
| res | output | 4 | Result digit |
| cy_out | output | 1 | Carry or borrow output, combinational |
| cy_flag | output | 1 | Registered copy of `cy_out` |

## Verification
The only internal state is the one-bit carry flag. A corrupted flag shows up at `cy_flag` one edge after the bad step, before the next digit could use it. A fault in decimal correction or in the code decode is combinational. It appears on `res` and `cy_out` in the same cycle as the stimulus. The bench visits every code with every operand pair and both carry inputs, so no such fault can stay hidden for more than the length of the sweep.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    localparam int DIGIT_W = 4;
    localparam int FN_W    = 3;
    localparam int SUM_W   = DIGIT_W + 1;

    typedef enum logic [FN_W-1:0] {
        OP_CLEAR   = 3'b000,
        OP_PASS_S  = 3'b001,
        OP_PASS_R  = 3'b010,
        OP_XOR     = 3'b011,
        OP_ADD_BIN = 3'b100,
        OP_ADD_DEC = 3'b101,
        OP_SUB_BIN = 3'b110,
        OP_SUB_DEC = 3'b111
    } alu_op_e;

endpackage

// File: rtl/nib_bin_core.sv
// Raw binary sum and difference of two digits with carry/borrow.
module nib_bin_core
    import nib_alu_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               ci,
    output logic [SUM_W-1:0]   sum,
    output logic [SUM_W-1:0]   dif,
    output logic               borrow
);

    always_comb begin
        sum    = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, ci};
        dif    = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, ci};
        // operands are at most 15, so bit 4 is a valid sign bit
        borrow = dif[SUM_W-1];
    end

endmodule

// File: rtl/nib_dec_adjust.sv
// Decimal correction of the raw sum and difference.
module nib_dec_adjust
    import nib_alu_pkg::*;
(
    input  logic [SUM_W-1:0]   sum,
    input  logic [SUM_W-1:0]   dif,
    input  logic               borrow,
    output logic [DIGIT_W-1:0] add_dec,
    output logic               add_cy,
    output logic [DIGIT_W-1:0] sub_dec
);

    localparam logic [SUM_W-1:0]   DEC_MAX = SUM_W'(9);
    localparam logic [DIGIT_W-1:0] DEC_FIX = DIGIT_W'(6);

    always_comb begin
        add_cy  = (sum > DEC_MAX);
        add_dec = add_cy ? (sum[DIGIT_W-1:0] + DEC_FIX) : sum[DIGIT_W-1:0];
        sub_dec = borrow ? (dif[DIGIT_W-1:0] - DEC_FIX) : dif[DIGIT_W-1:0];
    end

endmodule

// File: rtl/nib_carry_reg.sv
// Optional one-bit carry flag register.
module nib_carry_reg #(
    parameter bit REG_CARRY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cy_d,
    output logic cy_q
);

    generate
        if (REG_CARRY) begin : g_reg
            logic flag_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flag_q <= 1'b0;
                else        flag_q <= cy_d;
            end

            assign cy_q = flag_q;

            // R9: flag follows the carry of the previous edge
            p_flag_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> cy_q == $past(cy_d));
        end else begin : g_comb
            assign cy_q = cy_d;
        end
    endgenerate

endmodule

// File: rtl/nib_alu.sv
// Digit ALU: operation select over binary and decimal arithmetic.
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter bit REG_CARRY = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FN_W-1:0]    fn_code,
    input  logic [DIGIT_W-1:0] opd_s,
    input  logic [DIGIT_W-1:0] opd_r,
    input  logic               cy_in,
    output logic [DIGIT_W-1:0] res,
    output logic               cy_out,
    output logic               cy_flag
);

    alu_op_e            op;
    logic [SUM_W-1:0]   raw_sum;
    logic [SUM_W-1:0]   raw_dif;
    logic               raw_bor;
    logic [DIGIT_W-1:0] dec_add;
    logic               dec_add_cy;
    logic [DIGIT_W-1:0] dec_sub;

    assign op = alu_op_e'(fn_code);

    nib_bin_core u_bin (
        .a      (opd_s),
        .b      (opd_r),
        .ci     (cy_in),
        .sum    (raw_sum),
        .dif    (raw_dif),
        .borrow (raw_bor)
    );

    nib_dec_adjust u_dec (
        .sum     (raw_sum),
        .dif     (raw_dif),
        .borrow  (raw_bor),
        .add_dec (dec_add),
        .add_cy  (dec_add_cy),
        .sub_dec (dec_sub)
    );

    always_comb begin
        res    = '0;
        cy_out = 1'b0;
        unique case (op)
            OP_CLEAR:   begin res = '0;                  cy_out = 1'b0;             end
            OP_PASS_S:  begin res = opd_s;               cy_out = 1'b0;             end
            OP_PASS_R:  begin res = opd_r;               cy_out = 1'b0;             end
            OP_XOR:     begin res = opd_s ^ opd_r;       cy_out = 1'b0;             end
            OP_ADD_BIN: begin res = raw_sum[DIGIT_W-1:0]; cy_out = raw_sum[SUM_W-1]; end
            OP_ADD_DEC: begin res = dec_add;             cy_out = dec_add_cy;       end
            OP_SUB_BIN: begin res = raw_dif[DIGIT_W-1:0]; cy_out = raw_bor;          end
            OP_SUB_DEC: begin res = dec_sub;             cy_out = raw_bor;          end
            default:    begin res = '0;                  cy_out = 1'b0;             end
        endcase
    end

    nib_carry_reg #(.REG_CARRY(REG_CARRY)) u_cy (
        .clk   (clk),
        .rst_n (rst_n),
        .cy_d  (cy_out),
        .cy_q  (cy_flag)
    );

    // R1: idle code gives a zero digit and no carry
    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 3'b000) |-> (res == 4'd0 && !cy_out));

    // R4: logic and pass codes never raise carry
    p_logic_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code inside {3'b001, 3'b010, 3'b011}) |-> !cy_out);

    // R6: decimal add of valid digits yields a valid digit
    p_dec_add_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 3'b101 && opd_s <= 4'd9 && opd_r <= 4'd9) |-> res <= 4'd9);

    // R8: decimal subtract of valid digits yields a valid digit
    p_dec_sub_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 3'b111 && opd_s <= 4'd9 && opd_r <= 4'd9) |-> res <= 4'd9);

    // R5: binary add carry set only when the sum cannot fit in a digit
    p_bin_add_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 3'b100 && cy_out) |-> (res < opd_s || (res == opd_s && cy_in)));

endmodule

// File: tb/tb_nib_alu.sv
module tb_nib_alu;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fn_code = 3'b000;
    logic [3:0] opd_s = 4'd0;
    logic [3:0] opd_r = 4'd0;
    logic       cy_in = 1'b0;
    logic [3:0] res;
    logic       cy_out;
    logic       cy_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_alu dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .fn_code (fn_code),
        .opd_s   (opd_s),
        .opd_r   (opd_r),
        .cy_in   (cy_in),
        .res     (res),
        .cy_out  (cy_out),
        .cy_flag (cy_flag)
    );

    function automatic string req_of(int f);
        case (f)
            0: return "R1";
            1, 2: return "R2";
            3: return "R3";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (fn=%0d s=%0d r=%0d c=%0d)",
                     req, what, act, exp, fn_code, opd_s, opd_r, cy_in);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        int exp_y;
        int exp_c;
        int t;
        repeat (3) @(posedge clk);
        #1;
        check("R9", cy_flag, 0, "flag in reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 16; s++) begin
                for (int r = 0; r < 16; r++) begin
                    for (int c = 0; c < 2; c++) begin
                        @(negedge clk);
                        fn_code = 3'(f);
                        opd_s   = 4'(s);
                        opd_r   = 4'(r);
                        cy_in   = 1'(c);
                        exp_c = 0;
                        case (f)
                            0: exp_y = 0;
                            1: exp_y = s;
                            2: exp_y = r;
                            3: exp_y = s ^ r;
                            4: begin t = s + r + c; exp_y = t % 16; exp_c = t / 16; end
                            5: begin
                                t = s + r + c;
                                if (t > 9) begin exp_y = (t + 6) % 16; exp_c = 1; end
                                else exp_y = t;
                            end
                            6: begin
                                t = s - r - c;
                                exp_y = (t + 16) % 16;
                                exp_c = (t < 0) ? 1 : 0;
                            end
                            default: begin
                                t = s - r - c;
                                if (t < 0) begin exp_y = (t - 6 + 32) % 16; exp_c = 1; end
                                else exp_y = t;
                            end
                        endcase
                        #1;
                        check(req_of(f), res, exp_y, "result");
                        if (f >= 1 && f <= 3)
                            check("R4", cy_out, exp_c, "carry of logic op");
                        else
                            check(req_of(f), cy_out, exp_c, "carry");
                        if ((f == 5 || f == 7) && s <= 9 && r <= 9)
                            check(f == 5 ? "R6" : "R8", (res <= 9) ? 1 : 0, 1, "decimal range");
                        @(posedge clk);
                        #1;
                        check("R9", cy_flag, exp_c, "registered flag");
                    end
                end
            end
        end
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", cy_flag, 0, "flag cleared by reset");
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule